// File: doc/BRIEF.md
# Immediate-Operand ALU for 16-bit Compact Instructions

This block executes the four compact-encoding instructions that combine one low register with an 8-bit immediate: move, compare, add and subtract. It decodes one instruction halfword, reads the named register from its own eight-entry register file, and works out a write-back value and the next N, Z, C and V condition flags. All of this happens within the one cycle in which the instruction is presented.

An instruction is accepted on the rising clock edge where `instr_valid` is high and the group tag in bits [15:13] equals 3'b001. On that edge the flag register updates, and the destination register is written if the operation writes back. A halfword that carries a different group tag raises `illegal` and changes nothing. The data path width is the parameter `DATA_W`, which defaults to 32. The add and subtract wrap modulo 2^DATA_W, and the flags take their sign from bit DATA_W-1.

Top module: `imm_alu_top`

## Requirements
- R1: A synchronous active-low reset clears all four flags and every register-file entry to zero. After reset, an add of immediate 0 to any register shows write-back data 0.
- R2: Halfword layout: [15:13] group tag = 3'b001, [12:11] operation (00 move, 01 compare, 10 add, 11 subtract), [10:8] destination/source register, [7:0] zero-extended immediate. When `instr_valid` is high and the tag is not 001, `illegal` is 1, `wb_en` is 0, and neither the flags nor any register change.
- R3: Move writes the immediate to the register, clears N, sets Z exactly when the immediate is zero, and keeps C and V.
- R4: Compare produces register minus immediate modulo 2^DATA_W. It sets N from the top bit and Z when that difference is zero. It never asserts `wb_en`.
- R5: Compare and subtract set C exactly when the immediate is less than or equal to the register value, as unsigned numbers. C therefore means that no borrow occurred.
- R6: Compare and subtract set V to the top bit of ((reg XOR diff) AND (NOT imm XOR diff)).
- R7: Add writes the wrapped sum. It sets C from the unsigned carry out of the top bit, sets V to the top bit of ((reg XOR sum) AND (imm XOR sum)), and sets N and Z from the sum.
- R8: Subtract writes the wrapped difference and sets the flags by the same rules as compare.
- R9: While `instr_valid` is low, no flag and no register changes, and `wb_en` is 0.
- R10: `wb_en` is 1 exactly for a valid, legal move, add or subtract. `wb_idx` and `wb_data` then give the destination and its new value, and the register holds that value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe; the instruction takes effect on this edge |
| instr | input | 16 | Instruction halfword |
| illegal | output | 1 | Valid halfword whose group tag is not 001 |
| wb_en | output | 1 | Write-back enable for this cycle |
| wb_idx | output | 3 | Destination register index |
| wb_data | output | DATA_W (32) | Result value of this cycle |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry / no-borrow flag |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
Compares are run with the immediate equal to, one above and one below the register value. Together these separate the no-borrow rule for C from a strict less-than rule and check Z at the boundary. Registers are walked down to the most negative value and to all-ones. This lets subtract-from-minimum and add-to-maximum expose the signed overflow rules, and all-ones plus one expose the unsigned carry. Moves of zero and non-zero values follow instructions that left C and V set, which tells kept flags apart from cleared ones. Halfwords with a wrong group tag, and strobe-low cycles, are each followed by a read-back add of zero, which shows that neither reached the register file or the flags. A long pseudo-random mix then checks the same rules against a scoreboard at a reduced data width, so that wrap-around and overflow occur often.

// File: rtl/imm_alu_pkg.sv
// Package: shared encodings for the immediate-operand ALU.
// Assumes a 16-bit halfword with fixed field positions.
package imm_alu_pkg;

    localparam int INSTR_W   = 16;
    localparam int IMM_W     = 8;
    localparam int REG_CNT   = 8;
    localparam int IDX_W     = $clog2(REG_CNT);
    localparam int TAG_HI    = 15;
    localparam int TAG_LO    = 13;
    localparam int OP_HI     = 12;
    localparam int OP_LO     = 11;
    localparam int IDX_HI    = 10;
    localparam int IDX_LO    = 8;
    localparam logic [TAG_HI-TAG_LO:0] GROUP_TAG = 3'b001;

    typedef enum logic [1:0] {
        OP_MOV = 2'b00,
        OP_CMP = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/imm_alu_decode.sv
// Module: imm_alu_decode
// Splits an instruction halfword into group check, operation,
// register index and immediate. Purely combinational.
// Assumes the layout fixed in imm_alu_pkg.
module imm_alu_decode
    import imm_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output alu_op_e            op,
    output logic [IDX_W-1:0]   idx,
    output logic [IMM_W-1:0]   imm
);

    // Field extraction and group-tag match.
    always_comb begin
        legal = (instr[TAG_HI:TAG_LO] == GROUP_TAG);
        op    = alu_op_e'(instr[OP_HI:OP_LO]);
        idx   = instr[IDX_HI:IDX_LO];
        imm   = instr[IMM_W-1:0];
    end

endmodule

// File: rtl/imm_alu_regfile.sv
// Module: imm_alu_regfile
// Small register file: one asynchronous read port and one synchronous
// write port, cleared by synchronous active-low reset.
// Assumes a single writer; a write becomes readable the next cycle.
module imm_alu_regfile #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write the addressed row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && (waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    // Read mux.
    assign rdata = mem[raddr];

    // Per-row checks: a write lands, any other row holds.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row_chk
        p_row_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == AW'(g)) |=> (mem[g] == $past(wdata)));
        p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == AW'(g)) |=> $stable(mem[g]));
    end

endmodule

// File: rtl/imm_alu_core.sv
// Module: imm_alu_core
// Computes the result and next flags for move/compare/add/subtract
// of a register value and a zero-extended immediate.
// Assumes rhs already zero-extended; combinational only.
module imm_alu_core
    import imm_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int MSB   = DATA_W - 1
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  nzcv_t             flags_cur,
    output logic [DATA_W-1:0] result,
    output nzcv_t             flags_nxt,
    output logic              writes
);

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] diff;
    logic              no_borrow;
    logic              add_ovf;
    logic              sub_ovf;

    // Shared arithmetic for all operations.
    always_comb begin
        sum_ext   = {1'b0, lhs} + {1'b0, rhs};
        diff      = lhs - rhs;
        no_borrow = (rhs <= lhs);
        add_ovf   = ((lhs ^ sum_ext[MSB:0]) & (rhs ^ sum_ext[MSB:0])) >> MSB != '0;
        sub_ovf   = ((lhs ^ diff) & (~rhs ^ diff)) >> MSB != '0;
    end

    // Operation select: result, write intent and flag rules.
    always_comb begin
        flags_nxt = flags_cur;
        result    = diff;
        writes    = 1'b1;
        unique case (op)
            OP_MOV: begin
                result      = rhs;
                flags_nxt.n = 1'b0;
                flags_nxt.z = (rhs == '0);
            end
            OP_ADD: begin
                result      = sum_ext[MSB:0];
                flags_nxt.n = sum_ext[MSB];
                flags_nxt.z = (sum_ext[MSB:0] == '0);
                flags_nxt.c = sum_ext[DATA_W];
                flags_nxt.v = add_ovf;
            end
            OP_CMP, OP_SUB: begin
                writes      = (op == OP_SUB);
                flags_nxt.n = diff[MSB];
                flags_nxt.z = (diff == '0);
                flags_nxt.c = no_borrow;
                flags_nxt.v = sub_ovf;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/imm_alu_top.sv
// Module: imm_alu_top
// Executes one immediate-operand move/compare/add/subtract per cycle
// against an internal eight-entry register file, holding NZCV flags.
// Assumes instr is stable around the clock edge where instr_valid is high.
module imm_alu_top
    import imm_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    output logic              illegal,
    output logic              wb_en,
    output logic [2:0]        wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    logic              legal;
    alu_op_e           op;
    logic [IDX_W-1:0]  idx;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] result;
    logic              writes;
    logic              accept;
    nzcv_t             flags_q;
    nzcv_t             flags_nxt;

    imm_alu_decode u_dec (
        .instr (instr),
        .legal (legal),
        .op    (op),
        .idx   (idx),
        .imm   (imm)
    );

    imm_alu_regfile #(.DATA_W(DATA_W), .DEPTH(REG_CNT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_en),
        .waddr (idx),
        .wdata (result),
        .raddr (idx),
        .rdata (rd_data)
    );

    imm_alu_core #(.DATA_W(DATA_W)) u_core (
        .op        (op),
        .lhs       (rd_data),
        .rhs       (imm_ext),
        .flags_cur (flags_q),
        .result    (result),
        .flags_nxt (flags_nxt),
        .writes    (writes)
    );

    // Accept, write-back and illegal indication for this cycle.
    always_comb begin
        imm_ext = DATA_W'(imm);
        accept  = instr_valid && legal;
        illegal = instr_valid && !legal;
        wb_en   = accept && writes;
        wb_idx  = idx;
        wb_data = result;
    end

    // Flag register: cleared on reset, loaded on each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (accept)
            flags_q <= flags_nxt;
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0));
    p_illegal_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(flags_q));
    p_illegal_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wb_en);
    p_mov_keeps_cv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_MOV) |=> (!flags_q.n && flags_q.c == $past(flags_q.c)
                                      && flags_q.v == $past(flags_q.v)));
    p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> !wb_en);
    p_sub_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_SUB || op == OP_CMP)) |-> (wb_data + imm_ext == rd_data));
    p_add_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ADD) |=> (flags_q.c == ($past(wb_data) < $past(rd_data))));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(flags_q));

endmodule

// File: tb/tb_imm_alu_top.sv
`timescale 1ns/1ps
module tb_imm_alu_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [15:0]  instr = 16'h0;
    logic         illegal;
    logic         wb_en;
    logic [2:0]   wb_idx;
    logic [W-1:0] wb_data;
    logic         flag_n, flag_z, flag_c, flag_v;

    imm_alu_top #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .illegal(illegal), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic         ill;
        logic         wen;
        logic [2:0]   idx;
        logic [W-1:0] data;
        logic [3:0]   nzcv;
        int           req;
    } exp_t;

    exp_t         q[$];
    logic [W-1:0] mregs [8];
    logic [3:0]   mflags;
    int           checks = 0;
    int           errors = 0;
    logic [31:0]  seed = 32'h1234_5678;

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [2:0] rd,
                                       input logic [7:0] imm);
        return {3'b001, op, rd, imm};
    endfunction

    // Reference model: build the expected item and advance model state.
    function automatic exp_t model(input logic v, input logic [15:0] ins, input int req);
        exp_t e;
        logic [W-1:0] lhs, rhs, res;
        logic [W:0]   s;
        logic [3:0]   f;
        logic         wr;
        lhs = mregs[ins[10:8]];
        rhs = W'(ins[7:0]);
        f   = mflags;
        wr  = 1'b1;
        res = '0;
        case (ins[12:11])
            2'b00: begin res = rhs; f[3] = 1'b0; f[2] = (rhs == '0); end
            2'b10: begin
                s = {1'b0, lhs} + {1'b0, rhs};
                res = s[W-1:0];
                f = {res[W-1], res == '0, s[W], ((lhs ^ res) & (rhs ^ res)) >> (W-1) != '0};
            end
            default: begin
                res = lhs - rhs;
                wr  = ins[12:11] == 2'b11;
                f = {res[W-1], res == '0, rhs <= lhs, ((lhs ^ res) & (~rhs ^ res)) >> (W-1) != '0};
            end
        endcase
        e.req  = req;
        e.idx  = ins[10:8];
        e.data = res;
        e.ill  = v && ins[15:13] != 3'b001;
        e.wen  = v && !e.ill && wr;
        if (v && !e.ill) mflags = f;
        if (e.wen) mregs[ins[10:8]] = res;
        e.nzcv = mflags;
        return e;
    endfunction

    task automatic issue(input logic v, input logic [15:0] ins, input int req);
        @(negedge clk);
        instr_valid = v;
        instr = ins;
        q.push_back(model(v, ins, req));
    endtask

    task automatic chk(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare combinational outputs mid-cycle, flags after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                chk(q[0].req, "illegal", 32'(illegal), 32'(q[0].ill));
                chk(q[0].req, "wb_en", 32'(wb_en), 32'(q[0].wen));
                if (q[0].wen) begin
                    chk(q[0].req, "wb_idx", 32'(wb_idx), 32'(q[0].idx));
                    chk(q[0].req, "wb_data", 32'(wb_data), 32'(q[0].data));
                end
                @(posedge clk);
                #1;
                chk(q[0].req, "nzcv", 32'({flag_n, flag_z, flag_c, flag_v}), 32'(q[0].nzcv));
                void'(q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mregs[i] = '0;
        mflags = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: flags cleared after reset
        chk(1, "reset nzcv", 32'({flag_n, flag_z, flag_c, flag_v}), 32'h0);
        // R1: every register reads zero via add #0
        for (int r = 0; r < 8; r++) issue(1'b1, mk(2'b10, 3'(r), 8'h00), 1);
        // R3: moves, zero and non-zero
        issue(1'b1, mk(2'b00, 3'd1, 8'h00), 3);
        issue(1'b1, mk(2'b00, 3'd2, 8'h80), 3);
        issue(1'b1, mk(2'b00, 3'd3, 8'hFF), 3);
        // R4, R5: compare equal, above, below
        issue(1'b1, mk(2'b01, 3'd2, 8'h80), 5);
        issue(1'b1, mk(2'b01, 3'd2, 8'h81), 5);
        issue(1'b1, mk(2'b01, 3'd2, 8'h7F), 4);
        // R8: subtract to all-ones
        issue(1'b1, mk(2'b00, 3'd4, 8'h00), 3);
        issue(1'b1, mk(2'b11, 3'd4, 8'h01), 8);
        // R3: move after C set keeps C/V
        issue(1'b1, mk(2'b01, 3'd3, 8'h01), 5);
        issue(1'b1, mk(2'b00, 3'd7, 8'h05), 3);
        // Walk r5 to the most negative value
        issue(1'b1, mk(2'b00, 3'd5, 8'h00), 3);
        for (int k = 0; k < 8; k++) issue(1'b1, mk(2'b11, 3'd5, 8'hFF), 8);
        issue(1'b1, mk(2'b11, 3'd5, 8'h08), 8);
        // R6: compare from minimum overflows
        issue(1'b1, mk(2'b01, 3'd5, 8'h01), 6);
        issue(1'b1, mk(2'b11, 3'd5, 8'h01), 6);
        // R7: add at maximum overflows; all-ones plus one carries
        issue(1'b1, mk(2'b10, 3'd5, 8'h01), 7);
        issue(1'b1, mk(2'b10, 3'd4, 8'h01), 7);
        // R2: wrong group tag, then read back
        issue(1'b1, {3'b000, 2'b00, 3'd2, 8'h33}, 2);
        issue(1'b1, {3'b111, 2'b10, 3'd2, 8'h01}, 2);
        issue(1'b1, mk(2'b10, 3'd2, 8'h00), 2);
        // R9: strobe low, then read back
        issue(1'b0, mk(2'b00, 3'd3, 8'h11), 9);
        issue(1'b0, mk(2'b10, 3'd3, 8'h22), 9);
        issue(1'b1, mk(2'b10, 3'd3, 8'h00), 9);
        // R10: pseudo-random mix
        for (int n = 0; n < 600; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[31:28] == 4'h0)
                issue(1'b1, {seed[27:25] | 3'b010, seed[15:3]}, 2);
            else
                issue(seed[30:27] != 4'h1, {3'b001, seed[24:12]}, 10);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule